// File: doc/BRIEF.md
# Sticky Reset Cause Register

This block records which reset source caused the latest reset, so that software can find out afterwards why the chip restarted. It holds one flag for each source: an external hard reset, power-up, the software watchdog, a double bus fault, a loss of clock, and two kinds of software-commanded reset. Reset sources raise one-cycle request pulses while a reset is in progress. The block holds those causes in a pending latch. It moves them into the visible register only when the reset sequencer signals, with a strobe, that the reset sequence is over.

The flags are sticky. A new reset adds its own cause and leaves earlier flags set. Only a power-up reset, applied through the active-low power-up input, empties the register. The first completion strobe after power-up then sets both the power-up flag and the external-reset flag. Software running in supervisor mode reads the register at any time. It clears flags by writing ones to them. Bits written as zero keep their value, and one write may clear several bits.

Top module: `resetCauseReg`

## Requirements
- R1: While `pwrOnRstN` is low, and after it is released until the first `rstDone` pulse, the register reads 0x00. That first `rstDone` sets bit 7 (external) and bit 6 (power-up), so the register reads 0xC0.
- R2: A pulse on `rstReq` bit 7 (external), 5 (watchdog), 4 (double bus fault), 2 (loss of clock), 1 (software reset) or 0 (second software reset) sets the flag at the same bit position. The request is held pending and does not show in the register until the next `rstDone` pulse.
- R3: A commit ORs the new causes into the register, and flags set earlier stay set. Only a low level on `pwrOnRstN` clears flags without a write, and it clears all of them.
- R4: A supervisor write (`regSel`=1, `regWr`=1, `regSup`=1) clears every flag whose bit in `regWdata` is 1. Several flags can be cleared in a single write.
- R5: A flag whose `regWdata` bit is 0 during a supervisor write keeps its value.
- R6: If a commit sets a flag in the same cycle that a write clears it, the flag ends up set.
- R7: Bit 3 is reserved. It always reads 0, and writing 1 to it has no effect. `rstReq` bits 6 and 3 have no effect on the register.
- R8: When `regSup` is 0, a write changes no flag and `regRdata` is 0x00. When `regSel` is 0, `regRdata` is 0x00.
- R9: The value of the register appears on `regRdata` in the same cycle that `regSel`=1, `regWr`=0 and `regSup`=1. Reading has no side effect.
- R10: A commit empties the pending latch, so a later `rstDone` with no new request changes nothing. A request that arrives in the same cycle as `rstDone` is included in that commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| pwrOnRstN | input | 1 | Power-up reset indication, active low, asynchronous |
| rstReq | input | 8 | Per-source reset request pulses, aligned to the flag bit positions |
| rstDone | input | 1 | One-cycle strobe marking the end of the reset sequence |
| regSel | input | 1 | Register select |
| regWr | input | 1 | Write (1) or read (0) |
| regSup | input | 1 | The access is made in supervisor mode |
| regWdata | input | 8 | Write data, where a 1 clears the flag at that bit |
| regRdata | output | 8 | Read data |

## Verification
Two functions can act on the same flag in one cycle: a commit that sets the flag, and a software write that clears it by writing one. The bench latches a double-bus-fault request. It then pulses the completion strobe in the same cycle as a supervisor write of one to that bit, and requires the flag to read back as set while the other flags keep their values. A second case sends a request in the same cycle as the completion strobe and requires that the cause is committed at once rather than left in the pending latch.

// File: rtl/rcr_pkg.sv
package rcr_pkg;

  localparam int FLAG_W = 8;

  // Bit positions of the cause flags; software decodes these positions.
  localparam int BIT_EXT  = 7;
  localparam int BIT_PWR  = 6;
  localparam int BIT_WDOG = 5;
  localparam int BIT_DBF  = 4;
  localparam int BIT_RSVD = 3;
  localparam int BIT_LOC  = 2;
  localparam int BIT_SWR  = 1;
  localparam int BIT_SWRP = 0;

  typedef logic [FLAG_W-1:0] flagVec_t;

  // Positions that a request pulse may set.
  localparam flagVec_t REQ_MASK = (flagVec_t'(1) << BIT_EXT)  |
                                  (flagVec_t'(1) << BIT_WDOG) |
                                  (flagVec_t'(1) << BIT_DBF)  |
                                  (flagVec_t'(1) << BIT_LOC)  |
                                  (flagVec_t'(1) << BIT_SWR)  |
                                  (flagVec_t'(1) << BIT_SWRP);

  // Cause pending right after power-up: external and power-up together.
  localparam flagVec_t PWRUP_CAUSE = (flagVec_t'(1) << BIT_EXT) |
                                     (flagVec_t'(1) << BIT_PWR);

  // Strobes from control to datapath.
  typedef struct packed {
    logic commit;
    logic clear;
  } rcrStrobe_t;

endpackage

// File: rtl/rcr_ctrl.sv
module rcr_ctrl
  import rcr_pkg::*;
(
  input  logic       clk,
  input  logic       pwrOnRstN,
  input  flagVec_t   rstReq,
  input  logic       rstDone,
  input  logic       regSel,
  input  logic       regWr,
  input  logic       regSup,
  output rcrStrobe_t strb,
  output flagVec_t   setVec
);

  flagVec_t pendQ;
  flagVec_t reqMasked;

  assign reqMasked = rstReq & REQ_MASK;

  // The pending latch starts with the power-up cause, collects requests,
  // and is emptied by the completion strobe.
  always_ff @(posedge clk or negedge pwrOnRstN) begin
    if (!pwrOnRstN)   pendQ <= PWRUP_CAUSE;
    else if (rstDone) pendQ <= '0;
    else              pendQ <= pendQ | reqMasked;
  end

  always_comb begin
    strb.commit = rstDone;
    strb.clear  = regSel & regWr & regSup;
    setVec      = rstDone ? (pendQ | reqMasked) : '0;
  end

  // R10: a commit leaves the pending latch empty
  p_pend_empty_r10: assert property (@(posedge clk) disable iff (!pwrOnRstN)
    rstDone |=> (pendQ == '0));

  // R2: without a commit, pending causes are not lost
  p_pend_holds_r2: assert property (@(posedge clk) disable iff (!pwrOnRstN)
    !rstDone |=> ((pendQ & $past(pendQ)) == $past(pendQ)));

  // R7: the power-up and reserved positions never enter the latch from a request
  p_req_filter_r7: assert property (@(posedge clk) disable iff (!pwrOnRstN)
    !rstDone |=> ((pendQ & ~$past(pendQ) & ~REQ_MASK) == '0));

endmodule

// File: rtl/rcr_dpath.sv
module rcr_dpath
  import rcr_pkg::*;
(
  input  logic       clk,
  input  logic       pwrOnRstN,
  input  rcrStrobe_t strb,
  input  flagVec_t   setVec,
  input  flagVec_t   regWdata,
  input  logic       regSel,
  input  logic       regSup,
  output flagVec_t   regRdata
);

  flagVec_t flagQ;
  flagVec_t clrMask;

  assign clrMask = strb.clear ? regWdata : '0;

  for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
    if (i == BIT_RSVD) begin : g_rsvd
      assign flagQ[i] = 1'b0;
    end else begin : g_bit
      // A set wins over a clear in the same cycle.
      always_ff @(posedge clk or negedge pwrOnRstN) begin
        if (!pwrOnRstN) flagQ[i] <= 1'b0;
        else            flagQ[i] <= setVec[i] | (flagQ[i] & ~clrMask[i]);
      end
    end
  end

  assign regRdata = (regSel && regSup) ? flagQ : '0;

  // R6: every bit set by a commit is present afterwards
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!pwrOnRstN)
    strb.commit |=> ((flagQ & $past(setVec)) == $past(setVec)));

  // R4: bits written as one and not set in that cycle are cleared
  p_w1c_r4: assert property (@(posedge clk) disable iff (!pwrOnRstN)
    strb.clear |=> ((flagQ & $past(regWdata) & ~$past(setVec)) == '0));

  // R3: without a clear strobe no flag falls
  p_sticky_r3: assert property (@(posedge clk) disable iff (!pwrOnRstN)
    !strb.clear |=> ((flagQ & $past(flagQ)) == $past(flagQ)));

  // R2: without a commit no flag rises
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!pwrOnRstN)
    !strb.commit |=> ((flagQ & ~$past(flagQ)) == '0));

endmodule

// File: rtl/resetCauseReg.sv
module resetCauseReg
  import rcr_pkg::*;
(
  input  logic       clk,
  input  logic       pwrOnRstN,
  input  logic [7:0] rstReq,
  input  logic       rstDone,
  input  logic       regSel,
  input  logic       regWr,
  input  logic       regSup,
  input  logic [7:0] regWdata,
  output logic [7:0] regRdata
);

  rcrStrobe_t strb;
  flagVec_t   setVec;

  rcr_ctrl u_ctrl (
    .clk       (clk),
    .pwrOnRstN (pwrOnRstN),
    .rstReq    (rstReq),
    .rstDone   (rstDone),
    .regSel    (regSel),
    .regWr     (regWr),
    .regSup    (regSup),
    .strb      (strb),
    .setVec    (setVec)
  );

  rcr_dpath u_dpath (
    .clk       (clk),
    .pwrOnRstN (pwrOnRstN),
    .strb      (strb),
    .setVec    (setVec),
    .regWdata  (regWdata),
    .regSel    (regSel),
    .regSup    (regSup),
    .regRdata  (regRdata)
  );

  // R8: a non-supervisor access never exposes flag data
  p_nonsup_read_r8: assert property (@(posedge clk) disable iff (!pwrOnRstN)
    !regSup |-> (regRdata == 8'h00));

endmodule

// File: tb/resetCauseReg_test.sv
module resetCauseReg_test;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0] req;
    logic       done;
    logic       wr;
    logic       sup;
    logic [7:0] wdata;
    logic [7:0] exp;
    logic [7:0] tag;
  } vec_t;

  localparam int NVEC = 19;
  localparam vec_t VECS [NVEC] = '{
    '{8'h00, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00, 8'd1},  // R1 nothing before first commit
    '{8'h00, 1'b1, 1'b0, 1'b1, 8'h00, 8'hC0, 8'd1},  // R1 first commit gives 0xC0
    '{8'h00, 1'b0, 1'b1, 1'b1, 8'hFF, 8'h00, 8'd4},  // R4 multi-bit clear
    '{8'h20, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00, 8'd2},  // R2 pending, not visible
    '{8'h00, 1'b1, 1'b0, 1'b1, 8'h00, 8'h20, 8'd2},  // R2 committed
    '{8'h80, 1'b0, 1'b0, 1'b1, 8'h00, 8'h20, 8'd2},  // R2
    '{8'h00, 1'b1, 1'b0, 1'b1, 8'h00, 8'hA0, 8'd3},  // R3 sticky OR
    '{8'h00, 1'b0, 1'b1, 1'b1, 8'h00, 8'hA0, 8'd5},  // R5 zero write
    '{8'h00, 1'b0, 1'b1, 1'b1, 8'h80, 8'h20, 8'd4},  // R4 single clear
    '{8'h00, 1'b1, 1'b0, 1'b1, 8'h00, 8'h20, 8'd10}, // R10 empty commit
    '{8'h48, 1'b1, 1'b0, 1'b1, 8'h00, 8'h20, 8'd7},  // R7 bits 6,3 ignored
    '{8'h04, 1'b1, 1'b0, 1'b1, 8'h00, 8'h24, 8'd10}, // R10 same-cycle request
    '{8'h10, 1'b0, 1'b0, 1'b1, 8'h00, 8'h24, 8'd2},  // R2
    '{8'h00, 1'b1, 1'b1, 1'b1, 8'h10, 8'h34, 8'd6},  // R6 set wins
    '{8'h00, 1'b0, 1'b1, 1'b0, 8'h14, 8'h34, 8'd8},  // R8 user write ignored
    '{8'h03, 1'b0, 1'b0, 1'b1, 8'h00, 8'h34, 8'd2},  // R2
    '{8'h00, 1'b1, 1'b0, 1'b1, 8'h00, 8'h37, 8'd2},  // R2 both software kinds
    '{8'h00, 1'b0, 1'b1, 1'b1, 8'h08, 8'h37, 8'd7},  // R7 reserved write
    '{8'h00, 1'b0, 1'b1, 1'b1, 8'h37, 8'h00, 8'd4}   // R4
  };

  logic       clk = 1'b0;
  logic       pwrOnRstN;
  logic [7:0] rstReq;
  logic       rstDone;
  logic       regSel;
  logic       regWr;
  logic       regSup;
  logic [7:0] regWdata;
  logic [7:0] regRdata;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  resetCauseReg uut (
    .clk       (clk),
    .pwrOnRstN (pwrOnRstN),
    .rstReq    (rstReq),
    .rstDone   (rstDone),
    .regSel    (regSel),
    .regWr     (regWr),
    .regSup    (regSup),
    .regWdata  (regWdata),
    .regRdata  (regRdata)
  );

  task automatic check(input logic [7:0] expv, input string req);
    checks++;
    if (regRdata !== expv) begin
      fails++;
      $display("FAIL %s: regRdata=%02h expected=%02h", req, regRdata, expv);
    end
  endtask

  task automatic setRead(input logic sup, input logic sel);
    rstReq = 8'h00; rstDone = 1'b0; regWr = 1'b0; regWdata = 8'h00;
    regSel = sel; regSup = sup;
  endtask

  task automatic cycle(input logic [7:0] req, input logic done,
                       input logic wr, input logic sup, input logic [7:0] wd);
    @(negedge clk);
    rstReq = req; rstDone = done; regSel = wr; regWr = wr;
    regSup = sup; regWdata = wd;
    @(posedge clk);
    #1;
    setRead(1'b1, 1'b1);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    pwrOnRstN = 1'b0;
    setRead(1'b1, 1'b1);
    repeat (2) @(posedge clk);
    #1;
    check(8'h00, "R1 during power-up");
    @(negedge clk);
    pwrOnRstN = 1'b1;
    #1;
    check(8'h00, "R1 after release");

    for (int k = 0; k < NVEC; k++) begin
      cycle(VECS[k].req, VECS[k].done, VECS[k].wr, VECS[k].sup, VECS[k].wdata);
      checks++;
      if (regRdata !== VECS[k].exp) begin
        fails++;
        $display("FAIL R%0d vector %0d: regRdata=%02h expected=%02h",
                 VECS[k].tag, k, regRdata, VECS[k].exp);
      end
    end

    // Flags are 0x00; set the software-reset flag
    cycle(8'h02, 1'b1, 1'b0, 1'b1, 8'h00);
    check(8'h02, "R2 software reset");
    // R8 non-supervisor read and deselected read
    setRead(1'b0, 1'b1); #1;
    check(8'h00, "R8 user read");
    setRead(1'b1, 1'b0); #1;
    check(8'h00, "R8 deselected read");
    // R9 repeated reads have no side effect
    setRead(1'b1, 1'b1);
    repeat (3) @(posedge clk);
    #1;
    check(8'h02, "R9 repeated read");
    // R3 power-up clears everything
    @(negedge clk);
    pwrOnRstN = 1'b0;
    @(posedge clk);
    #1;
    check(8'h00, "R3 power-up clears");
    @(negedge clk);
    pwrOnRstN = 1'b1;
    #1;
    check(8'h00, "R1 before commit");
    cycle(8'h00, 1'b1, 1'b0, 1'b1, 8'h00);
    check(8'hC0, "R1 power-up commit");

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule